// File: doc/BRIEF.md
# Serial Control Port with Register File

This block sits behind a four-wire synchronous serial control port. It holds the small set of configuration registers that the rest of a voice-band channel reads. A host drives a control clock and an active-low chip select. While the select is low it shifts 8-bit instruction bytes in on a serial data line, most significant bit first. Each first byte carries four things: a power-state bit, a 4-bit register address, a read/write flag and a one/two-byte flag. A two-byte write stores the following data byte in the addressed register. A two-byte read shifts that register's contents out on a serial output, which the pad drives only while an enable is asserted.

The port pins are treated as asynchronous to the system clock. They are synchronised and their edges are detected on the system clock, so the control clock must run well below it. The host should hold each control-clock phase for at least four system-clock cycles. The control clock idles low between pulses. A pulse is a rising edge followed by a falling edge. Input bits are taken on falling edges, and read data is driven on rising edges.

The serial protocol has no flow control, so there is no back-pressure. A byte is accepted when its eighth falling edge arrives, and the host must keep pace with read data. The power flag and the register contents are plain level outputs.

Top module: `scp_ctrl_port`

## Requirements
- R1: After reset, `power_down` is 1, every register in `regs_o` is zero and `sdo_oe` is 0.
- R2: In a first byte, bit 7 (the first bit sent) is the power flag. Bits 6..3 are the address, bit 2 is 1 for read and 0 for write, bit 1 is 1 for a two-byte instruction, and bit 0 is ignored. The power flag is copied to `power_down` (1 = powered down) when the eighth bit of every first byte is received, and at no other time.
- R3: A first byte with bit 1 = 0 changes only `power_down`, whatever its address and read flag. No register changes, and no read data is driven.
- R4: A two-byte write stores the second byte in the addressed register on that byte's eighth falling edge. The register slots in `regs_o` are addressed as follows, with slot n at bits 8n+7..8n: 0000→0, 0001→1, 0010→2, 0100→3, 0101→4, 0110→5, 0111→6, 1000→7, 1001→8, 1010→9.
- R5: The second byte may be sent in the same select-low window as the first byte, or in a later window after the select was released on a byte boundary.
- R6: After a two-byte read first byte, the addressed register is driven on `sdo` MSB first, one bit per rising edge of the next eight clock pulses. This holds whether the select stays low or is taken low again.
- R7: Writes to address codes outside the R4 map change no register, and reads of them return all zeros.
- R8: If the select rises after 1 to 7 bits of any byte, the instruction is dropped. No register changes, `power_down` keeps its value from the last complete first byte, and the next window starts a new first byte.
- R9: `sdo_oe` is 0 whenever `cs_n` is high. It is 1 only during the data byte of a read.
- R10: With the select held low throughout, any number of instructions may follow one another back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cclk | input | 1 | Serial control clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| power_down | output | 1 | Power state, 1 = powered down |
| regs_o | output | 80 | Ten 8-bit registers, slot n at bits 8n+7..8n |

## Verification
The assertions check, on every cycle, the following:
- the output enable stays off while the select is high;
- a select release returns the bit count to zero;
- the power flag moves only when a first byte completes;
- a single-byte instruction never leaves the command phase;
- the registers hold still unless a write to a mapped address occurs.

Only the bench scenarios can show that real transfers produce the right values. They cover:
- bit order and the address-to-slot mapping;
- read data returned MSB first, in one select window or split across two;
- undefined addresses reading as zero;
- partial bytes in either byte position leaving state intact, with the next full instruction still landing correctly.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int NUM_SLOTS = 10;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int CNT_W     = $clog2(BYTE_W);

  // first-byte field positions (bit 7 is shifted first)
  localparam int PWR_BIT = 7;
  localparam int ADR_HI  = 6;
  localparam int ADR_LO  = 3;
  localparam int RD_BIT  = 2;
  localparam int TWO_BIT = 1;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

  function automatic logic slot_valid(input logic [ADDR_W-1:0] a);
    case (a)
      4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA: slot_valid = 1'b1;
      default: slot_valid = 1'b0;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    case (a)
      4'h0: slot_of = SLOT_W'(0);
      4'h1: slot_of = SLOT_W'(1);
      4'h2: slot_of = SLOT_W'(2);
      4'h4: slot_of = SLOT_W'(3);
      4'h5: slot_of = SLOT_W'(4);
      4'h6: slot_of = SLOT_W'(5);
      4'h7: slot_of = SLOT_W'(6);
      4'h8: slot_of = SLOT_W'(7);
      4'h9: slot_of = SLOT_W'(8);
      4'hA: slot_of = SLOT_W'(9);
      default: slot_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scp_frame.sv
module scp_frame
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cclk_s,
  input  logic              cs_s,
  input  logic              sdi_s,
  output logic              rise_o,
  output logic              power_down_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_load_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_phase_o
);
  logic              cclk_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] in_sh;
  logic [ADDR_W-1:0] addr_q;
  logic              pwr_q;
  phase_e            phase;

  logic [BYTE_W-1:0] nxt;
  logic              fall, last_bit, byte_done, cmd_done;

  assign nxt       = {in_sh, sdi_s};
  assign fall      = cclk_q & ~cclk_s & ~cs_s;
  assign rise_o    = ~cclk_q & cclk_s;
  assign last_bit  = (bit_cnt == CNT_W'(BYTE_W-1));
  assign byte_done = fall & last_bit;
  assign cmd_done  = byte_done & (phase == PH_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cclk_q  <= 1'b0;
      bit_cnt <= '0;
      in_sh   <= '0;
      addr_q  <= '0;
      pwr_q   <= 1'b1;
      phase   <= PH_CMD;
    end else begin
      cclk_q <= cclk_s;
      if (cs_s) begin
        // released mid-byte: drop the instruction
        if (bit_cnt != '0) begin
          bit_cnt <= '0;
          phase   <= PH_CMD;
        end
      end else if (fall) begin
        in_sh <= nxt[BYTE_W-2:0];
        if (last_bit) begin
          bit_cnt <= '0;
          if (phase == PH_CMD) begin
            pwr_q  <= nxt[PWR_BIT];
            addr_q <= nxt[ADR_HI:ADR_LO];
            if (nxt[TWO_BIT]) phase <= nxt[RD_BIT] ? PH_READ : PH_WRITE;
          end else begin
            phase <= PH_CMD;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign power_down_o = pwr_q;
  assign wr_en_o      = byte_done & (phase == PH_WRITE);
  assign wr_addr_o    = addr_q;
  assign wr_data_o    = nxt;
  assign rd_load_o    = cmd_done & nxt[TWO_BIT] & nxt[RD_BIT];
  assign rd_addr_o    = nxt[ADR_HI:ADR_LO];
  assign rd_phase_o   = (phase == PH_READ);

  // R8
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == '0));

  // R2
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_done |=> $stable(pwr_q));

  // R3
  single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !nxt[TWO_BIT]) |=> (phase == PH_CMD));
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [BYTE_W-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [BYTE_W-1:0]           rd_data_o,
  output logic [NUM_SLOTS*BYTE_W-1:0] regs_o
);
  logic                  wr_ok;
  logic [SLOT_W-1:0]     wr_slot;
  logic [BYTE_W-1:0]     slot_q [NUM_SLOTS];

  assign wr_ok   = wr_en_i & slot_valid(wr_addr_i);
  assign wr_slot = slot_of(wr_addr_i);

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  slot_q[s] <= '0;
        else if (wr_ok && wr_slot == SLOT_W'(s))     slot_q[s] <= wr_data_i;
      end
      assign regs_o[s*BYTE_W +: BYTE_W] = slot_q[s];
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_valid(rd_addr_i) && slot_of(rd_addr_i) == SLOT_W'(s)) rd_data_o = slot_q[s];
    end
  end

  // R7
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !slot_valid(wr_addr_i)) |=> $stable(regs_o));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(regs_o));
endmodule

// File: rtl/scp_readout.sv
module scp_readout
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              cs_s,
  input  logic              rise_i,
  input  logic              rd_phase_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [BYTE_W-1:0] sh_q;
  logic              sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= load_data_i;
    end else if (rise_i && !cs_s && rd_phase_i) begin
      sdo_q <= sh_q[BYTE_W-1];
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = ~cs_n_i & rd_phase_i;

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sh_q == $past(load_data_i)));
endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cclk,
  input  logic                        cs_n,
  input  logic                        sdi,
  output logic                        sdo,
  output logic                        sdo_oe,
  output logic                        power_down,
  output logic [NUM_SLOTS*BYTE_W-1:0] regs_o
);
  logic cclk_s, cs_s, sdi_s;
  logic rise, wr_en, rd_load, rd_phase;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  scp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_cclk (
    .clk(clk), .rst_n(rst_n), .d_i(cclk), .q_o(cclk_s));
  scp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
    .clk(clk), .rst_n(rst_n), .d_i(cs_n), .q_o(cs_s));
  scp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sdi (
    .clk(clk), .rst_n(rst_n), .d_i(sdi), .q_o(sdi_s));

  scp_frame i_frame (
    .clk(clk), .rst_n(rst_n), .cclk_s(cclk_s), .cs_s(cs_s), .sdi_s(sdi_s),
    .rise_o(rise), .power_down_o(power_down),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_load_o(rd_load), .rd_addr_o(rd_addr), .rd_phase_o(rd_phase));

  scp_regfile i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .regs_o(regs_o));

  scp_readout i_readout (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cs_s(cs_s), .rise_i(rise),
    .rd_phase_i(rd_phase), .load_i(rd_load), .load_data_i(rd_data),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe));

  // R9
  oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo_oe);
endmodule

// File: tb/test_scp_ctrl_port.sv
module test_scp_ctrl_port;
  localparam int H  = 6;
  localparam int NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, cclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, power_down;
  logic [NS*8-1:0] regs_o;

  int checks = 0, fails = 0;
  logic [7:0] exp_regs [NS];
  logic [3:0] addr_tab [NS] = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA};

  always #10 clk = ~clk;

  scp_ctrl_port i_scp_ctrl_port (
    .clk(clk), .rst_n(rst_n), .cclk(cclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .power_down(power_down), .regs_o(regs_o));

  function automatic logic [7:0] cmd(input logic p, input logic [3:0] a,
                                     input logic rd, input logic two);
    return {p, a, rd, two, 1'b0};
  endfunction

  function automatic logic [NS*8-1:0] model();
    logic [NS*8-1:0] v;
    for (int s = 0; s < NS; s++) v[s*8 +: 8] = exp_regs[s];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [NS*8-1:0] act,
                     input logic [NS*8-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sdi = b; tick(H);
    cclk = 1'b1; tick(H);
    r = sdo;
    cclk = 1'b0; tick(H);
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic bits_x(input logic [7:0] tx, input int n);
    logic r;
    for (int i = 7; i > 7 - n; i--) bit_x(tx[i], r);
  endtask

  task automatic cs_lo(); cs_n = 1'b0; tick(H); endtask
  task automatic cs_hi(); cs_n = 1'b1; tick(2*H); endtask

  task automatic t_reset();
    chk(power_down == 1'b1, "R1 power_down", power_down, 1);
    chk(regs_o == '0, "R1 regs", regs_o, 0);
    chk(sdo_oe == 1'b0, "R1 sdo_oe", sdo_oe, 0);
  endtask

  task automatic t_power_only();
    logic [7:0] rx;
    cs_lo(); byte_x(cmd(1'b0, 4'h0, 1'b0, 1'b0), rx); cs_hi();
    chk(power_down == 1'b0, "R2 power up", power_down, 0);
    chk(regs_o == model(), "R3 regs untouched", regs_o, model());
    cs_lo(); byte_x(cmd(1'b1, 4'h1, 1'b1, 1'b0), rx);
    chk(sdo_oe == 1'b0, "R3 no read drive", sdo_oe, 0);
    cs_hi();
    chk(power_down == 1'b1, "R3 power down", power_down, 1);
    chk(regs_o == model(), "R3 regs untouched", regs_o, model());
  endtask

  task automatic t_write_all();
    logic [7:0] rx, d;
    cs_lo();
    for (int s = 0; s < NS; s++) begin
      d = 8'(s * 37 + 5) ^ 8'h80;
      byte_x(cmd(1'b0, addr_tab[s], 1'b0, 1'b1), rx);
      byte_x(d, rx);
      exp_regs[s] = d;
    end
    cs_hi();
    chk(regs_o == model(), "R4 R10 back-to-back writes", regs_o, model());
    chk(power_down == 1'b0, "R2 power from write", power_down, 0);
  endtask

  task automatic t_write_split();
    logic [7:0] rx;
    cs_lo(); byte_x(cmd(1'b1, 4'h8, 1'b0, 1'b1), rx); cs_hi();
    chk(power_down == 1'b1, "R2 power after first byte", power_down, 1);
    chk(regs_o == model(), "R5 no write yet", regs_o, model());
    cs_lo(); byte_x(8'hA5, rx); cs_hi();
    exp_regs[7] = 8'hA5;
    chk(regs_o == model(), "R5 split write", regs_o, model());
  endtask

  task automatic t_read_all();
    logic [7:0] rx;
    cs_lo();
    for (int s = 0; s < NS; s++) begin
      byte_x(cmd(1'b0, addr_tab[s], 1'b1, 1'b1), rx);
      byte_x(8'h00, rx);
      chk(rx == exp_regs[s], "R6 R10 readback", rx, exp_regs[s]);
    end
    cs_hi();
    chk(sdo_oe == 1'b0, "R9 oe off after read", sdo_oe, 0);
  endtask

  task automatic t_read_split();
    logic [7:0] rx;
    cs_lo(); byte_x(cmd(1'b0, 4'h5, 1'b1, 1'b1), rx); cs_hi();
    chk(sdo_oe == 1'b0, "R9 oe off between windows", sdo_oe, 0);
    cs_lo();
    chk(sdo_oe == 1'b1, "R9 oe on in read byte", sdo_oe, 1);
    byte_x(8'h00, rx); cs_hi();
    chk(rx == exp_regs[4], "R6 split read", rx, exp_regs[4]);
  endtask

  task automatic t_undef();
    logic [7:0] rx;
    logic [3:0] bad [3] = '{4'h3, 4'hB, 4'hF};
    for (int k = 0; k < 3; k++) begin
      cs_lo();
      byte_x(cmd(1'b0, bad[k], 1'b0, 1'b1), rx);
      byte_x(8'hFF, rx);
      byte_x(cmd(1'b0, bad[k], 1'b1, 1'b1), rx);
      byte_x(8'h00, rx);
      cs_hi();
      chk(regs_o == model(), "R7 write discarded", regs_o, model());
      chk(rx == 8'h00, "R7 read zero", rx, 0);
    end
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    cs_lo(); bits_x(cmd(1'b1, 4'h0, 1'b0, 1'b1), 3); cs_hi();
    chk(power_down == 1'b0, "R8 power kept on byte-one abort", power_down, 0);
    cs_lo(); byte_x(cmd(1'b0, 4'h4, 1'b0, 1'b1), rx); bits_x(8'h3C, 5); cs_hi();
    chk(regs_o == model(), "R8 no write on byte-two abort", regs_o, model());
    cs_lo(); byte_x(cmd(1'b0, 4'h4, 1'b0, 1'b1), rx); byte_x(8'h3C, rx); cs_hi();
    exp_regs[3] = 8'h3C;
    chk(regs_o == model(), "R8 resync after abort", regs_o, model());
  endtask

  initial begin
    for (int s = 0; s < NS; s++) exp_regs[s] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_power_only();
    t_write_all();
    t_write_split();
    t_read_all();
    t_read_split();
    t_undef();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule